// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer sits between the issue stage of a wide SIMT core and the global-memory path. One warp memory instruction arrives as a single request: one address for each of the 32 lanes, a shared per-lane access size, a mask of the lanes that take part, and a flag that marks the instruction as a store. The block merges the lane accesses into as few aligned memory transactions as it can. Each transaction is 32, 64 or 128 bytes long. The transactions leave one at a time over a valid/ready handshake.

Each outgoing transaction carries three things: its aligned base address, a size code, and the set of lanes it serves. For stores it also carries a mask of the lanes whose data is kept. When several lanes store to the same word, exactly one lane's data is kept, and that lane is the highest-numbered one. The block holds one warp request at a time. It stops taking requests until every transaction of the current request has been handed off.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `busy` and `txn_valid` are low and `req_ready` is high.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while `busy` is high, and any request offered during that time is ignored and has no effect on the transactions emitted.
- R3: Each lane address is aligned down to the access size before grouping. The address bits below the access size are ignored. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes.
- R4: Every active lane (a set bit in `req_mask`, where bit i is lane i) is served by exactly one transaction. No inactive lane ever appears in `txn_lanes`.
- R5: Transactions go out in order of the lowest-numbered lane not yet served. Each transaction serves every unserved active lane whose aligned address lies in the same 128-byte aligned segment as that leading lane.
- R6: `txn_size` is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. A transaction is 32 bytes when all the lanes it serves fall in one 32-byte quarter of the segment. It is 64 bytes when they all fall in one 64-byte half. Otherwise it is 128 bytes. `txn_addr` is aligned to the transaction length, and the range it covers contains the address of every lane it serves.
- R7: For a store, `txn_wmask` has one bit set for each distinct aligned word in the transaction. That bit belongs to the highest-numbered served lane that addresses the word. For a load, `txn_wmask` is zero.
- R8: While `txn_valid` is high and `txn_ready` is low, `txn_valid` and all transaction fields hold steady. A transaction is consumed only on a cycle where both are high.
- R9: `busy` is high from the cycle after a request with a non-empty mask is accepted until the cycle after its last transaction is consumed. A request with an empty mask produces no transaction and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | The block can take a request |
| req_store | input | 1 | 1 = store instruction, 0 = load |
| req_size | input | 2 | Per-lane access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_mask | input | LANES | Active lane mask, bit i = lane i |
| req_addr | input | LANES*AW | Lane addresses; lane i at bits [i*AW +: AW] |
| busy | output | 1 | A request still has transactions to emit |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_addr | output | AW | Aligned base address of the transaction |
| txn_size | output | 2 | Length code (0:32B, 1:64B, 2:128B) |
| txn_lanes | output | LANES | Lanes served by the transaction |
| txn_wmask | output | LANES | Lanes whose store data is kept |

## Verification
The assertions check the following on every cycle:
- the handshake hold rule;
- that pending lanes never grow while busy;
- that served lanes are cleared after a handoff;
- that every transaction holds the lowest pending lane;
- that the base is aligned and covers each served lane address;
- that the kept-data mask stays inside the served set and is empty for loads.

Only the bench scenarios can show the following:
- that the grouping is minimal and in the right order;
- that the length shrinks correctly for each spread of addresses;
- which lane wins a duplicated store word;
- that address bits below the access size are ignored.

The bench checks these against a model of its own that works from the minimum and maximum segment offsets.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    SEG_32  = 2'd0,
    SEG_64  = 2'd1,
    SEG_128 = 2'd2
  } seg_size_e;

  // Low address bits kept for a given per-lane access size code.
  function automatic logic [2:0] keep_low(input logic [1:0] size_code);
    case (size_code)
      2'd0:    keep_low = 3'b111;
      2'd1:    keep_low = 3'b110;
      2'd2:    keep_low = 3'b100;
      default: keep_low = 3'b000;
    endcase
  endfunction

  // Segment length from the set of touched quarters.
  function automatic seg_size_e pick_len(input logic [3:0] qhit);
    if ($countones(qhit) <= 1)                    pick_len = SEG_32;
    else if (qhit[1:0] == 2'b00 || qhit[3:2] == 2'b00) pick_len = SEG_64;
    else                                          pick_len = SEG_128;
  endfunction

  // Quarter index of the segment base for the chosen length.
  function automatic logic [1:0] pick_quarter(input logic [3:0] qhit);
    logic [1:0] q;
    q = 2'd0;
    if ($countones(qhit) <= 1) begin
      for (int k = 3; k >= 0; k--) if (qhit[k]) q = 2'(k);
    end else if (qhit[1:0] == 2'b00) begin
      q = 2'd2;
    end
    pick_quarter = q;
  endfunction

endpackage

// File: rtl/coal_lane_match.sv
module coal_lane_match #(
  parameter int LANES = 32,
  parameter int TAGW  = 25
) (
  input  logic [LANES-1:0]           pend,
  input  logic [LANES-1:0][TAGW-1:0] tags,
  output logic [LANES-1:0]           match,
  output logic [TAGW-1:0]            lead_tag
);
  localparam int LIDX = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LIDX-1:0] lead_idx;

  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lead_idx = LIDX'(i);
    end
  end

  assign lead_tag = tags[lead_idx];

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign match[i] = pend[i] && (tags[i] == lead_tag);
  end
endmodule

// File: rtl/coal_seg_shrink.sv
module coal_seg_shrink #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0]        match,
  input  logic [LANES-1:0][1:0]   quarter,
  output coal_pkg::seg_size_e     len,
  output logic [1:0]              base_q
);
  logic [3:0] qhit;

  always_comb begin
    qhit = '0;
    for (int i = 0; i < LANES; i++) begin
      if (match[i]) qhit[quarter[i]] = 1'b1;
    end
  end

  assign len    = coal_pkg::pick_len(qhit);
  assign base_q = coal_pkg::pick_quarter(qhit);

  // R6: a 32-byte result names a quarter that a served lane touches
  always_comb begin
    if (match != '0 && len == coal_pkg::SEG_32) begin
      a_r6_quarter_hit: assert (qhit[base_q]);
    end
  end
endmodule

// File: rtl/coal_dup_resolve.sv
module coal_dup_resolve #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                     is_store,
  input  logic [LANES-1:0]         match,
  input  logic [LANES-1:0][AW-1:0] addrs,
  output logic [LANES-1:0]         wmask
);
  for (genvar i = 0; i < LANES; i++) begin : g_win
    always_comb begin
      wmask[i] = is_store && match[i];
      for (int j = i + 1; j < LANES; j++) begin
        if (match[j] && addrs[j] == addrs[i]) wmask[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES     = 32,
  parameter int AW        = 32,
  parameter int SEG_BYTES = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic [LANES-1:0]      req_mask,
  input  logic [LANES*AW-1:0]   req_addr,
  output logic                  busy,
  output logic                  txn_valid,
  input  logic                  txn_ready,
  output logic [AW-1:0]         txn_addr,
  output logic [1:0]            txn_size,
  output logic [LANES-1:0]      txn_lanes,
  output logic [LANES-1:0]      txn_wmask
);
  localparam int SEG_LSB = $clog2(SEG_BYTES);
  localparam int Q_LSB   = SEG_LSB - 2;
  localparam int TAGW    = AW - SEG_LSB;
  localparam logic [AW-1:0] Q_BYTES = AW'(SEG_BYTES / 4);

  logic [LANES-1:0]           pend_q;
  logic [LANES-1:0][AW-1:0]   addr_q;
  logic                       store_q;
  logic [LANES-1:0][TAGW-1:0] tags;
  logic [LANES-1:0][1:0]      quarter;
  logic [LANES-1:0]           match;
  logic [TAGW-1:0]            lead_tag;
  coal_pkg::seg_size_e        seg_len;
  logic [1:0]                 base_q;
  logic                       accept;
  logic                       fire;
  logic [AW-1:0]              seg_span;

  assign busy      = |pend_q;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign txn_valid = busy;
  assign fire      = txn_valid && txn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      store_q <= 1'b0;
      addr_q  <= '0;
    end else if (accept) begin
      pend_q  <= req_mask;
      store_q <= req_store;
      for (int i = 0; i < LANES; i++) begin
        addr_q[i] <= {req_addr[i*AW+3 +: AW-3],
                      req_addr[i*AW +: 3] & coal_pkg::keep_low(req_size)};
      end
    end else if (fire) begin
      pend_q <= pend_q & ~match;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign tags[i]    = addr_q[i][AW-1:SEG_LSB];
    assign quarter[i] = addr_q[i][SEG_LSB-1:Q_LSB];
  end

  coal_lane_match #(.LANES(LANES), .TAGW(TAGW)) u_match (
    .pend     (pend_q),
    .tags     (tags),
    .match    (match),
    .lead_tag (lead_tag)
  );

  coal_seg_shrink #(.LANES(LANES)) u_shrink (
    .match   (match),
    .quarter (quarter),
    .len     (seg_len),
    .base_q  (base_q)
  );

  coal_dup_resolve #(.LANES(LANES), .AW(AW)) u_dup (
    .is_store (store_q),
    .match    (match),
    .addrs    (addr_q),
    .wmask    (txn_wmask)
  );

  always_comb begin
    txn_addr = {lead_tag, base_q, {Q_LSB{1'b0}}};
    if (seg_len == coal_pkg::SEG_64)  txn_addr[Q_LSB] = 1'b0;
    if (seg_len == coal_pkg::SEG_128) txn_addr[SEG_LSB-1:Q_LSB] = 2'b00;
  end
  assign txn_size  = seg_len;
  assign txn_lanes = match;
  assign seg_span  = Q_BYTES << txn_size;

  // R8: offered transaction holds under backpressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) &&
      $stable(txn_size) && $stable(txn_lanes) && $stable(txn_wmask));

  // R2: pending set never gains lanes while busy
  a_r2_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pend_q & ~$past(pend_q)) == '0);

  // R4: handed-off lanes are gone next cycle
  a_r4_served_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q & $past(txn_lanes)) == '0);

  // R4: served lanes are pending, never empty
  a_r4_lanes_pending: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_lanes != '0 && (txn_lanes & ~pend_q) == '0);

  // R5: the lowest pending lane is always in the offered transaction
  a_r5_leader: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((pend_q & (~pend_q + 1'b1)) & txn_lanes) != '0);

  // R6: base aligned to the transaction length
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_addr & (seg_span - 1'b1)) == '0);

  // R7: kept-data lanes are a subset of served lanes; none for loads
  a_r7_wmask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_wmask & ~txn_lanes) == '0);
  a_r7_load_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !store_q |-> txn_wmask == '0);

  // R9: a non-empty request raises busy on the next cycle
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mask != '0 |=> busy);

  for (genvar i = 0; i < LANES; i++) begin : g_cover_chk
    // R6: every served lane lies inside the transaction range
    a_r6_covers: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_lanes[i] |-> (addr_q[i] - txn_addr) < seg_span);
  end
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int L = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_store = 1'b0;
  logic [1:0]      req_size = 2'd0;
  logic [L-1:0]    req_mask = '0;
  logic [L*32-1:0] req_addr = '0;
  logic            busy;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [31:0]     txn_addr;
  logic [1:0]      txn_size;
  logic [L-1:0]    txn_lanes;
  logic [L-1:0]    txn_wmask;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] a [L];
  logic [31:0] e_addr [L];
  logic [1:0]  e_size [L];
  logic [L-1:0] e_lanes [L];
  logic [L-1:0] e_wmask [L];
  int          e_n;

  always #5 clk = ~clk;

  warp_coalescer u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_size, .req_mask,
    .req_addr, .busy, .txn_valid, .txn_ready, .txn_addr, .txn_size,
    .txn_lanes, .txn_wmask
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference grouping computed from min/max offsets in each segment.
  task automatic model(input bit st, input logic [1:0] sz, input logic [L-1:0] m);
    logic [31:0] al [L];
    logic [L-1:0] left;
    left = m;
    e_n  = 0;
    for (int i = 0; i < L; i++) al[i] = a[i] & ~((32'd1 << sz) - 32'd1);
    while (left != '0) begin
      int ld;
      logic [24:0] seg;
      logic [6:0] lo, hi;
      logic [L-1:0] grp, wm;
      ld = 0;
      for (int i = L - 1; i >= 0; i--) if (left[i]) ld = i;
      seg = al[ld][31:7];
      lo = 7'h7f; hi = 7'h00; grp = '0;
      for (int i = 0; i < L; i++) begin
        if (left[i] && al[i][31:7] == seg) begin
          grp[i] = 1'b1;
          if (al[i][6:0] < lo) lo = al[i][6:0];
          if (al[i][6:0] > hi) hi = al[i][6:0];
        end
      end
      wm = '0;
      if (st) begin
        for (int i = 0; i < L; i++) begin
          if (grp[i]) begin
            bit top;
            top = 1'b1;
            for (int j = i + 1; j < L; j++) if (grp[j] && al[j] == al[i]) top = 1'b0;
            wm[i] = top;
          end
        end
      end
      if (lo[6:5] == hi[6:5]) begin
        e_size[e_n] = 2'd0; e_addr[e_n] = {seg, lo[6:5], 5'd0};
      end else if (lo[6] == hi[6]) begin
        e_size[e_n] = 2'd1; e_addr[e_n] = {seg, lo[6], 6'd0};
      end else begin
        e_size[e_n] = 2'd2; e_addr[e_n] = {seg, 7'd0};
      end
      e_lanes[e_n] = grp;
      e_wmask[e_n] = wm;
      e_n++;
      left &= ~grp;
    end
  endtask

  task automatic run_req(input string tag, input bit st, input logic [1:0] sz,
                         input logic [L-1:0] m, input int stall, input bit poke);
    int got, cyc;
    bit held;
    logic [31:0] p_addr;
    logic [1:0] p_size;
    logic [L-1:0] p_lanes, p_wm;
    model(st, sz, m);
    @(negedge clk);
    for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = a[i];
    req_store = st; req_size = sz; req_mask = m; req_valid = 1'b1;
    chk(req_ready == 1'b1, {tag, " R2 ready when idle"}, 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == (m != '0), {tag, " R9 busy after accept"}, 64'(busy), 64'(m != '0));
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        req_valid = 1'b1; req_addr = '0; req_mask = '1; req_store = ~st;
        chk(req_ready == 1'b0, {tag, " R2 blocked while busy"}, 64'(req_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    got = 0; cyc = 0; held = 1'b0;
    p_addr = '0; p_size = '0; p_lanes = '0; p_wm = '0;
    while (busy && cyc < 2000) begin
      if (held) begin
        chk(txn_valid && txn_addr == p_addr && txn_size == p_size &&
            txn_lanes == p_lanes && txn_wmask == p_wm, {tag, " R8 hold"},
            {txn_lanes, txn_addr}, {p_lanes, p_addr});
      end
      txn_ready = (stall == 0) || (cyc % stall != 0);
      held = txn_valid && !txn_ready;
      p_addr = txn_addr; p_size = txn_size; p_lanes = txn_lanes; p_wm = txn_wmask;
      if (txn_valid && txn_ready) begin
        if (got < e_n) begin
          chk(txn_addr == e_addr[got] && txn_size == e_size[got],
              {tag, " R5 R6 base/size"}, {30'd0, txn_size, txn_addr},
              {30'd0, e_size[got], e_addr[got]});
          chk(txn_lanes == e_lanes[got], {tag, " R4 R5 lanes"},
              64'(txn_lanes), 64'(e_lanes[got]));
          chk(txn_wmask == e_wmask[got], {tag, " R7 wmask"},
              64'(txn_wmask), 64'(e_wmask[got]));
        end
        got++;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    txn_ready = 1'b0;
    chk(cyc < 2000, {tag, " R9 drains"}, 64'(cyc), 64'd2000);
    chk(got == e_n, {tag, " R4 transaction count"}, 64'(got), 64'(e_n));
    chk(!busy && !txn_valid && req_ready, {tag, " R9 idle after drain"},
        {62'd0, busy, txn_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !txn_valid && req_ready, "R1 reset state",
        {61'd0, busy, txn_valid, req_ready}, 64'd1);
  endtask

  task automatic t_unit_stride;
    for (int i = 0; i < L; i++) a[i] = 32'h1000 + 32'(4 * i);
    run_req("unit4B", 1'b0, 2'd2, '1, 0, 1'b0);
    chk(e_n == 1 && e_size[0] == 2'd2, "R6 unit stride one 128B", 64'(e_n), 64'd1);
  endtask

  task automatic t_wide_store;
    for (int i = 0; i < L; i++) a[i] = 32'h2000 + 32'(8 * i);
    run_req("wide8B", 1'b1, 2'd3, '1, 3, 1'b0);
  endtask

  task automatic t_bytes;
    for (int i = 0; i < L; i++) a[i] = 32'h3000 + 32'(i);
    run_req("bytes", 1'b0, 2'd0, '1, 0, 1'b0);
    chk(e_size[0] == 2'd0, "R6 byte lanes one 32B", 64'(e_size[0]), 64'd0);
  endtask

  task automatic t_scatter;
    for (int i = 0; i < L; i++) a[i] = 32'h4000 + 32'(128 * i) + 32'(4 * (i % 8));
    run_req("scatter", 1'b0, 2'd2, 32'h0F0F_00F5, 2, 1'b0);
  endtask

  task automatic t_half;
    for (int i = 0; i < L; i++) a[i] = 32'h5040 + 32'(2 * i);
    run_req("upperhalf", 1'b1, 2'd1, '1, 0, 1'b0);
    chk(e_size[0] == 2'd1 && e_addr[0] == 32'h5040, "R6 upper half 64B",
        64'(e_addr[0]), 64'h5040);
  endtask

  task automatic t_interleave;
    for (int i = 0; i < L; i++)
      a[i] = (i % 2 == 0) ? 32'h6000 + 32'(4 * i) : 32'h6100 + 32'(4 * i);
    run_req("interleave", 1'b0, 2'd2, '1, 0, 1'b0);
  endtask

  task automatic t_dup;
    for (int i = 0; i < L; i++) a[i] = 32'h7010;
    run_req("dupstore", 1'b1, 2'd2, 32'h7FFF_FFFF, 0, 1'b0);
    chk(e_wmask[0] == 32'h4000_0000, "R7 highest active lane wins",
        64'(e_wmask[0]), 64'h4000_0000);
    run_req("dupload", 1'b0, 2'd2, '1, 0, 1'b0);
  endtask

  task automatic t_misalign;
    for (int i = 0; i < L; i++) a[i] = 32'h8000 + 32'(i);
    run_req("R3 lowbits", 1'b1, 2'd2, '1, 0, 1'b0);
    chk(e_wmask[0] == 32'h8888_8888, "R3 one winner per aligned word",
        64'(e_wmask[0]), 64'h8888_8888);
  endtask

  task automatic t_empty;
    for (int i = 0; i < L; i++) a[i] = 32'h9000;
    run_req("empty", 1'b1, 2'd2, '0, 0, 1'b0);
    @(negedge clk);
    chk(!txn_valid && !busy, "R9 empty mask emits nothing",
        {62'd0, txn_valid, busy}, 64'd0);
  endtask

  task automatic t_poke;
    for (int i = 0; i < L; i++) a[i] = 32'hA000 + 32'(64 * i);
    run_req("poke", 1'b0, 2'd2, 32'hFFFF_0003, 2, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unit_stride();
    t_wide_store();
    t_bytes();
    t_scatter();
    t_half();
    t_interleave();
    t_dup();
    t_misalign();
    t_empty();
    t_poke();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule